// File: doc/BRIEF.md
# Debug Halt Mode Controller

This block keeps track of the debug operating mode of a processor core. It has three modes: running with debug disabled, running with debug enabled, and halted. While halted, the core runs no application code and only waits for debug commands. Already-decoded debug commands, a halt-instruction strobe and a breakpoint trigger move the block between modes. The reset cause and the level of the single background pin decide whether the core boots into halt or into run.

The block also drives the debug serial clock select, the stop-mode clock keep-alive and the enable bit. It turns a halt instruction that arrives while debug is disabled into a one-cycle reset or exception request. The serial protocol on the background pin, command decoding and the clock divider are outside this block.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, `mode_o` is 0 and `halt_o`, `dbg_en_o`, `clk_sel_o`, `stop_keep_o`, `ill_rst_req_o` and `ill_exc_req_o` are all 0. Mode encoding: 0 = run with debug off, 1 = run with debug on, 2 = halted.
- R2: The first clock edge after reset release is the boot cycle. At that edge the block enters halt if any of these holds:
  - `por_i` or `force_rst_i` is set with `bkgd_i` low;
  - `force_rst_i` and `force_halt_i` are both set;
  - for some bit n, `fault_rst_i[n]` and `fault_halt_en_i[n]` are both set (bit 0 watchdog, bit 1 illegal opcode, bit 2 illegal address).
  Entering halt at boot sets `dbg_en_o` and `clk_sel_o` to 1. Command inputs have no effect in the boot cycle.
- R3: Any other reset cause boots into mode 0 with `clk_sel_o` 0.
- R4: In mode 1, a pulse on `bg_cmd_i`, `halt_insn_i` or `bkpt_i` moves the block to mode 2 one cycle later.
- R5: In mode 2, `go_cmd_i` moves the block to mode 1. In modes 0 and 1, `go_cmd_i` has no effect.
- R6: In mode 0, `en_set_i` moves the block to mode 1. `en_clr_i` moves the block to mode 0 from any mode.
- R7: When events arrive in the same cycle, `en_clr_i` wins over `go_cmd_i`, which wins over halt-entry events. In mode 0, `en_set_i` wins over halt-entry events.
- R8: In mode 0, `bg_cmd_i` and `bkpt_i` leave the mode unchanged.
- R9: A `halt_insn_i` in mode 0 produces a one-cycle pulse on the next cycle. The pulse is `ill_rst_req_o` when `insn_rst_dis_i` is 0 and `ill_exc_req_o` when it is 1. The two requests are never high together, and a halt instruction in mode 1 or 2 raises neither.
- R10: `clk_sel_o` (1 = debug serial clock is CPU clock / 2, 0 = alternate source) changes only in the boot cycle and keeps its value across later mode changes.
- R11: `dbg_en_o` and `stop_keep_o` are 1 in modes 1 and 2 and 0 in mode 0. `halt_o` is 1 only in mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_i | input | 1 | Reset cause: power-on |
| force_rst_i | input | 1 | Reset cause: reset forced through debug |
| force_halt_i | input | 1 | Force-halt control for a forced debug reset |
| bkgd_i | input | 1 | Background pin level sampled at reset |
| fault_rst_i | input | N_FAULT | Fault reset causes (watchdog, illegal opcode, illegal address) |
| fault_halt_en_i | input | N_FAULT | Halt-on-reset enable for each fault cause |
| bg_cmd_i | input | 1 | Background (halt) command |
| go_cmd_i | input | 1 | Go (resume) command |
| en_set_i | input | 1 | Set debug enable |
| en_clr_i | input | 1 | Clear debug enable |
| halt_insn_i | input | 1 | Halt instruction executed |
| bkpt_i | input | 1 | Breakpoint trigger |
| insn_rst_dis_i | input | 1 | 1: an illegal halt raises an exception, 0: it raises a reset |
| mode_o | output | 2 | Current mode |
| halt_o | output | 1 | Core halted |
| dbg_en_o | output | 1 | Debug enable bit |
| clk_sel_o | output | 1 | Debug serial clock select |
| stop_keep_o | output | 1 | Keep core and debug clocks running in stop |
| ill_rst_req_o | output | 1 | Illegal halt reset request |
| ill_exc_req_o | output | 1 | Illegal halt exception request |

## Verification
The mode register feeds `mode_o`, `halt_o`, `dbg_en_o` and `stop_keep_o` directly, so a wrong transition shows on those ports on the cycle after the edge that caused it. A wrong boot decision shows on the first cycle after reset release. A clock select that drifts shows on `clk_sel_o` as soon as a later command changes the mode. A bad illegal-halt judgement shows as a wrong or missing request pulse one cycle after the halt strobe. Each scenario therefore samples one cycle after each stimulus and once more to confirm that request pulses last only one cycle.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;
  localparam int unsigned MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    MODE_RUN_OFF = 2'd0,
    MODE_RUN_ON  = 2'd1,
    MODE_HALT    = 2'd2
  } mode_e;
endpackage

// File: rtl/dbg_boot_sel.sv
module dbg_boot_sel #(
  parameter int unsigned N_FAULT = 3
) (
  input  logic               por_i,
  input  logic               force_rst_i,
  input  logic               force_halt_i,
  input  logic               bkgd_i,
  input  logic [N_FAULT-1:0] fault_rst_i,
  input  logic [N_FAULT-1:0] fault_halt_en_i,
  output logic               boot_halt_o
);
  logic [N_FAULT-1:0] fault_hit;

  for (genvar g = 0; g < N_FAULT; g++) begin : g_fault
    assign fault_hit[g] = fault_rst_i[g] & fault_halt_en_i[g];
  end

  logic pin_halt, forced_halt;
  assign pin_halt    = (por_i | force_rst_i) & ~bkgd_i;
  assign forced_halt = force_rst_i & force_halt_i;
  assign boot_halt_o = pin_halt | forced_halt | (|fault_hit);
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
  import dbg_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  boot_halt_i,
  input  logic  bg_cmd_i,
  input  logic  go_cmd_i,
  input  logic  en_set_i,
  input  logic  en_clr_i,
  input  logic  halt_insn_i,
  input  logic  bkpt_i,
  output mode_e mode_o,
  output logic  clk_sel_o,
  output logic  boot_o
);
  mode_e mode_q, mode_d;
  logic  clk_sel_q, clk_sel_d;
  logic  boot_q;
  logic  halt_evt;

  assign halt_evt = bg_cmd_i | halt_insn_i | bkpt_i;

  always_comb begin
    mode_d    = mode_q;
    clk_sel_d = clk_sel_q;
    if (boot_q) begin
      // boot cycle: reset cause decides, commands are ignored
      if (boot_halt_i) begin
        mode_d    = MODE_HALT;
        clk_sel_d = 1'b1;
      end else begin
        mode_d    = MODE_RUN_OFF;
      end
    end else if (en_clr_i) begin
      mode_d = MODE_RUN_OFF;
    end else begin
      unique case (mode_q)
        MODE_HALT:    if (go_cmd_i) mode_d = MODE_RUN_ON;
        MODE_RUN_ON:  if (halt_evt) mode_d = MODE_HALT;
        MODE_RUN_OFF: if (en_set_i) mode_d = MODE_RUN_ON;
        default:      mode_d = MODE_RUN_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_RUN_OFF;
      clk_sel_q <= 1'b0;
      boot_q    <= 1'b1;
    end else begin
      mode_q    <= mode_d;
      clk_sel_q <= clk_sel_d;
      boot_q    <= 1'b0;
    end
  end

  assign mode_o    = mode_q;
  assign clk_sel_o = clk_sel_q;
  assign boot_o    = boot_q;
endmodule

// File: rtl/dbg_illegal_halt.sv
module dbg_illegal_halt
  import dbg_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  boot_i,
  input  mode_e mode_i,
  input  logic  halt_insn_i,
  input  logic  insn_rst_dis_i,
  output logic  rst_req_o,
  output logic  exc_req_o
);
  logic illegal;
  logic rst_req_q, exc_req_q;

  assign illegal = ~boot_i & (mode_i == MODE_RUN_OFF) & halt_insn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_q <= 1'b0;
      exc_req_q <= 1'b0;
    end else begin
      rst_req_q <= illegal & ~insn_rst_dis_i;
      exc_req_q <= illegal &  insn_rst_dis_i;
    end
  end

  assign rst_req_o = rst_req_q;
  assign exc_req_o = exc_req_q;
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int unsigned N_FAULT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_i,
  input  logic               force_rst_i,
  input  logic               force_halt_i,
  input  logic               bkgd_i,
  input  logic [N_FAULT-1:0] fault_rst_i,
  input  logic [N_FAULT-1:0] fault_halt_en_i,
  input  logic               bg_cmd_i,
  input  logic               go_cmd_i,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  input  logic               halt_insn_i,
  input  logic               bkpt_i,
  input  logic               insn_rst_dis_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic               halt_o,
  output logic               dbg_en_o,
  output logic               clk_sel_o,
  output logic               stop_keep_o,
  output logic               ill_rst_req_o,
  output logic               ill_exc_req_o
);
  logic  boot_halt;
  logic  boot_q;
  mode_e mode;

  dbg_boot_sel #(.N_FAULT(N_FAULT)) i_boot_sel (
    .por_i          (por_i),
    .force_rst_i    (force_rst_i),
    .force_halt_i   (force_halt_i),
    .bkgd_i         (bkgd_i),
    .fault_rst_i    (fault_rst_i),
    .fault_halt_en_i(fault_halt_en_i),
    .boot_halt_o    (boot_halt)
  );

  dbg_mode_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boot_halt_i(boot_halt),
    .bg_cmd_i   (bg_cmd_i),
    .go_cmd_i   (go_cmd_i),
    .en_set_i   (en_set_i),
    .en_clr_i   (en_clr_i),
    .halt_insn_i(halt_insn_i),
    .bkpt_i     (bkpt_i),
    .mode_o     (mode),
    .clk_sel_o  (clk_sel_o),
    .boot_o     (boot_q)
  );

  dbg_illegal_halt i_illegal (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .boot_i        (boot_q),
    .mode_i        (mode),
    .halt_insn_i   (halt_insn_i),
    .insn_rst_dis_i(insn_rst_dis_i),
    .rst_req_o     (ill_rst_req_o),
    .exc_req_o     (ill_exc_req_o)
  );

  assign mode_o      = mode;
  assign halt_o      = (mode == MODE_HALT);
  assign dbg_en_o    = (mode != MODE_RUN_OFF);
  assign stop_keep_o = dbg_en_o;
endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
module dbg_mode_ctrl_chk
  import dbg_mode_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              boot_i,
  input logic              bg_cmd_i,
  input logic              go_cmd_i,
  input logic              en_set_i,
  input logic              en_clr_i,
  input logic              halt_insn_i,
  input logic              bkpt_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              halt_i,
  input logic              dbg_en_i,
  input logic              clk_sel_i,
  input logic              rst_req_i,
  input logic              exc_req_i
);
  AST_BOOT_HALT_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_i |=> (!halt_i || (dbg_en_i && clk_sel_i))); // R2
  AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_i && mode_i == MODE_RUN_ON && (bg_cmd_i || halt_insn_i || bkpt_i) && !en_clr_i)
    |=> mode_i == MODE_HALT); // R4
  AST_GO_RESUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_i && mode_i == MODE_HALT && go_cmd_i && !en_clr_i) |=> mode_i == MODE_RUN_ON); // R5
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_i && en_clr_i) |=> mode_i == MODE_RUN_OFF); // R7
  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_i && mode_i == MODE_RUN_OFF && !en_set_i) |=> mode_i == MODE_RUN_OFF); // R8
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_i && exc_req_i)); // R9
  AST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_i || exc_req_i) |-> $past(!boot_i && mode_i == MODE_RUN_OFF && halt_insn_i)); // R9
  AST_CLKSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_i |=> $stable(clk_sel_i)); // R10
endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boot_i     (boot_q),
  .bg_cmd_i   (bg_cmd_i),
  .go_cmd_i   (go_cmd_i),
  .en_set_i   (en_set_i),
  .en_clr_i   (en_clr_i),
  .halt_insn_i(halt_insn_i),
  .bkpt_i     (bkpt_i),
  .mode_i     (mode_o),
  .halt_i     (halt_o),
  .dbg_en_i   (dbg_en_o),
  .clk_sel_i  (clk_sel_o),
  .rst_req_i  (ill_rst_req_o),
  .exc_req_i  (ill_exc_req_o)
);

// File: tb/test_dbg_mode_ctrl.sv
module test_dbg_mode_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por, frc, fhalt, bkgd;
  logic [2:0] flt, flt_en;
  logic bg, go, es, ec, hi, bk, rdis;
  logic [1:0] mode;
  logic halt, en, csel, keep, rreq, ereq;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dbg_mode_ctrl i_dbg_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por), .force_rst_i(frc),
    .force_halt_i(fhalt), .bkgd_i(bkgd), .fault_rst_i(flt),
    .fault_halt_en_i(flt_en), .bg_cmd_i(bg), .go_cmd_i(go),
    .en_set_i(es), .en_clr_i(ec), .halt_insn_i(hi), .bkpt_i(bk),
    .insn_rst_dis_i(rdis), .mode_o(mode), .halt_o(halt),
    .dbg_en_o(en), .clk_sel_o(csel), .stop_keep_o(keep),
    .ill_rst_req_o(rreq), .ill_exc_req_o(ereq)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // mode plus the bits derived from it (R11)
  task automatic chk_mode(string tag, int exp);
    chk(tag, int'(mode), exp);
    chk({tag, "/R11 en"}, int'(en), int'(exp != 0));
    chk({tag, "/R11 keep"}, int'(keep), int'(exp != 0));
    chk({tag, "/R11 halt"}, int'(halt), int'(exp == 2));
  endtask

  task automatic idle();
    bg = 0; go = 0; es = 0; ec = 0; hi = 0; bk = 0;
  endtask

  task automatic do_reset(logic p, logic f, logic fh, logic b, logic [2:0] fr, logic [2:0] fe);
    @(negedge clk);
    rst_ni = 1'b0;
    por = p; frc = f; fhalt = fh; bkgd = b; flt = fr; flt_en = fe;
    @(negedge clk);
    chk("R1 mode", int'(mode), 0);
    chk("R1 outs", int'({halt, en, csel, keep, rreq, ereq}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    por = 0; frc = 0; fhalt = 0; bkgd = 1; flt = '0; flt_en = '0;
  endtask

  task automatic step(logic b_, logic g_, logic s_, logic c_, logic h_, logic k_);
    bg = b_; go = g_; es = s_; ec = c_; hi = h_; bk = k_;
    @(negedge clk);
    idle();
  endtask

  task automatic t_boot_halt();
    do_reset(1, 0, 0, 0, 3'b000, 3'b000); chk_mode("R2 por pin low", 2);
    chk("R2 clksel", int'(csel), 1);
    do_reset(0, 1, 0, 0, 3'b000, 3'b000); chk_mode("R2 forced pin low", 2);
    do_reset(0, 1, 1, 1, 3'b000, 3'b000); chk_mode("R2 forced halt bit", 2);
    do_reset(0, 0, 0, 1, 3'b001, 3'b001); chk_mode("R2 watchdog", 2);
    do_reset(0, 0, 0, 1, 3'b010, 3'b010); chk_mode("R2 illegal op", 2);
    do_reset(0, 0, 0, 1, 3'b100, 3'b100); chk_mode("R2 illegal addr", 2);
    chk("R2 clksel addr", int'(csel), 1);
  endtask

  task automatic t_boot_run();
    do_reset(1, 0, 0, 1, 3'b000, 3'b000); chk_mode("R3 por pin high", 0);
    chk("R3 clksel", int'(csel), 0);
    do_reset(0, 1, 0, 1, 3'b000, 3'b000); chk_mode("R3 forced no halt", 0);
    do_reset(0, 0, 0, 1, 3'b001, 3'b110); chk_mode("R3 watchdog no en", 0);
    do_reset(0, 0, 0, 1, 3'b010, 3'b101); chk_mode("R3 mismatched en", 0);
    // set-enable held through boot cycle is ignored
    @(negedge clk); rst_ni = 0; por = 1; bkgd = 1; flt = '0; flt_en = '0; frc = 0; fhalt = 0;
    es = 1;
    @(negedge clk); rst_ni = 1;
    @(negedge clk); es = 0; por = 0;
    chk_mode("R2 boot ignores cmd", 0);
  endtask

  task automatic t_entry();
    do_reset(1, 0, 0, 0, 3'b000, 3'b000);
    step(0, 1, 0, 0, 0, 0); chk_mode("R5 go", 1);
    step(1, 0, 0, 0, 0, 0); chk_mode("R4 bg", 2);
    step(0, 1, 0, 0, 0, 0);
    rdis = 0;
    step(0, 0, 0, 0, 1, 0); chk_mode("R4 halt insn", 2);
    chk("R9 no req legal", int'({rreq, ereq}), 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1); chk_mode("R4 bkpt", 2);
    chk("R10 clksel kept", int'(csel), 1);
  endtask

  task automatic t_go_enable();
    do_reset(1, 0, 0, 1, 3'b000, 3'b000);
    step(0, 1, 0, 0, 0, 0); chk_mode("R5 go in off", 0);
    step(0, 0, 1, 0, 0, 0); chk_mode("R6 set", 1);
    step(0, 1, 0, 0, 0, 0); chk_mode("R5 go in on", 1);
    step(0, 0, 0, 1, 0, 0); chk_mode("R6 clr from on", 0);
    step(0, 0, 0, 1, 0, 0); chk_mode("R6 clr in off", 0);
    do_reset(1, 0, 0, 0, 3'b000, 3'b000);
    step(0, 0, 0, 1, 0, 0); chk_mode("R6 clr from halt", 0);
    chk("R10 clksel after clr", int'(csel), 1);
    step(0, 0, 1, 0, 0, 0); chk_mode("R6 set again", 1);
    chk("R10 clksel after set", int'(csel), 1);
  endtask

  task automatic t_priority();
    do_reset(1, 0, 0, 0, 3'b000, 3'b000);
    step(0, 1, 0, 1, 0, 0); chk_mode("R7 clr over go", 0);
    step(0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 1, 0, 1); chk_mode("R7 clr over halt", 0);
    step(0, 0, 1, 0, 0, 1); chk_mode("R7 set over bkpt", 1);
  endtask

  task automatic t_off_ignore();
    do_reset(1, 0, 0, 1, 3'b000, 3'b000);
    step(1, 0, 0, 0, 0, 0); chk_mode("R8 bg in off", 0);
    step(0, 0, 0, 0, 0, 1); chk_mode("R8 bkpt in off", 0);
  endtask

  task automatic t_illegal();
    do_reset(1, 0, 0, 1, 3'b000, 3'b000);
    rdis = 0;
    step(0, 0, 0, 0, 1, 0);
    chk("R9 rst req", int'(rreq), 1);
    chk("R9 no exc", int'(ereq), 0);
    chk_mode("R9 mode kept", 0);
    @(negedge clk);
    chk("R9 rst pulse ends", int'(rreq), 0);
    rdis = 1;
    step(0, 0, 0, 0, 1, 0);
    chk("R9 exc req", int'(ereq), 1);
    chk("R9 no rst", int'(rreq), 0);
    @(negedge clk);
    chk("R9 exc pulse ends", int'(ereq), 0);
    rdis = 0;
  endtask

  initial begin
    idle(); rdis = 0;
    por = 0; frc = 0; fhalt = 0; bkgd = 1; flt = '0; flt_en = '0;
    t_boot_halt();
    t_boot_run();
    t_entry();
    t_go_enable();
    t_priority();
    t_off_ignore();
    t_illegal();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule